// File: doc/BRIEF.md
# Handshaked Sixteen-Line Output Port

This block is a bus-mapped output port that drives sixteen digital lines. Software stores a word in the data register. It can write the whole word or either byte on its own, so the lines serve as single bits, as two 8-bit lanes, or as one 16-bit word. Each lane has its own strobe, which pulses for one clock whenever that lane is written. The port can also invert all sixteen lines from a panel switch input, and a control bit can override that switch.

The port also runs a completion handshake. A device on the far side acknowledges each transfer by toggling a reply input. The reply is synchronized and edge-detected, and the chosen edge sets a done flag. When interrupts are enabled, the done flag raises a request. The request is withdrawn when the processor acknowledges it, and the port drives a fixed vector onto the read data during that acknowledge. Writing the data register clears done, ready for the next transfer. The control word can also fake a reply from software and pick which reply edge counts.

The register bus is plain and synchronous. It has a select, a write flag, a word address, byte enables and write data. Read data is combinational. The control word sits at the base address (octal 171260) and the data register at base + 2. Because the port has no buffering, there is no back-pressure: every selected bus cycle completes in the cycle it is presented.

Top module: `dout_hs_port`

## Requirements
- R1: After reset the output lines are 0 (with the panel switch off), both strobes are low, the interrupt request is low, and both registers read 0.
- R2: A data register write with both byte enables loads all sixteen lines. Both strobes (bit 0 = low lane, bit 1 = high lane) are high for exactly the one clock that follows the write edge.
- R3: A data register write with a single byte enable (bit 0 = bits 7:0, bit 1 = bits 15:8) changes only that lane and pulses only that lane's strobe.
- R4: The data register reads back the stored value, before any inversion. While the panel input is high, the lines show the complement of that value. When control bit 4 is set, the panel input is ignored.
- R5: The reply input passes through a two-flop synchronizer. With control bit 3 clear, a falling reply edge sets done (control bit 7) on the third clock edge after the change, and a rising edge is ignored. With bit 3 set, the rising edge counts and the falling edge is ignored.
- R6: Writing 1 to control bit 0 sets done as a reply would. Bit 0 always reads 0.
- R7: Any data register write clears done. A control write to the low byte with bit 7 = 0 also clears done, and one with bit 7 = 1 leaves done as it is. A reply or simulated reply in the same cycle wins over a clear.
- R8: The interrupt request rises on the clock where done and interrupt-enable (control bit 6) first become true together, in either order. While the request is acknowledged, the read data is octal 340 (0x00E0). The request is low on the clock after the acknowledge.
- R9: With interrupt-enable clear, no request is raised. Clearing it withdraws a pending request and leaves done set.
- R10: Control bits 6, 4 and 3 read back what was written through the low byte. Bits 15:8, 5, 2, 1 and 0 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Bus cycle addresses this block |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 16 | Byte address of the word accessed |
| bus_be | input | 2 | Byte enables for writes |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data or interrupt vector |
| panel_inv | input | 1 | Panel switch requesting output inversion |
| reply_in | input | 1 | Asynchronous reply from the external device |
| dout | output | 16 | Output lines |
| dout_stb | output | 2 | Per-lane update strobes |
| irq_req | output | 1 | Interrupt request |
| irq_ack | input | 1 | Interrupt acknowledge |

## Verification
The assertions assume several things about the inputs. A bus cycle lasts one clock. The acknowledge is only given while a request is pending. The reply input is quiet until reset is released. Under these assumptions, the request can only stand while done and enable are both set, and a write always produces its strobe on the following clock. The stimulus drives every input on the falling clock edge. It keeps each bus access to a single cycle, raises the acknowledge only after it has seen the request, and waits at least four clocks between reply edges so that each edge reaches the synchronizer cleanly.

// File: rtl/dout_hs_pkg.sv
package dout_hs_pkg;
  localparam int unsigned BIT_DONE    = 7;
  localparam int unsigned BIT_IE      = 6;
  localparam int unsigned BIT_DEFEAT  = 4;
  localparam int unsigned BIT_POSEDGE = 3;
  localparam int unsigned BIT_SIM     = 0;

  typedef struct packed {
    logic done;
    logic ie;
    logic defeat;
    logic pos_edge;
  } ctl_t;

  function automatic logic [15:0] ctl_word(ctl_t c);
    logic [15:0] w;
    w = '0;
    w[BIT_DONE]    = c.done;
    w[BIT_IE]      = c.ie;
    w[BIT_DEFEAT]  = c.defeat;
    w[BIT_POSEDGE] = c.pos_edge;
    return w;
  endfunction
endpackage

// File: rtl/dout_reply_sync.sv
module dout_reply_sync #(
  parameter int unsigned STAGES = 2,
  parameter logic        IDLE   = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] stage_q;
  logic              prev_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) stage_q[0] <= IDLE;
          else        stage_q[0] <= async_in;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rst_n) stage_q[s] <= IDLE;
          else        stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= IDLE;
    else        prev_q <= stage_q[STAGES-1];
  end

  assign rise = stage_q[STAGES-1] & ~prev_q;
  assign fall = ~stage_q[STAGES-1] & prev_q;
endmodule

// File: rtl/dout_lane_reg.sv
module dout_lane_reg #(
  parameter int unsigned WIDTH = 16,
  localparam int unsigned LANES = WIDTH / 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [LANES-1:0] be,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] value,
  output logic [LANES-1:0] stb
);
  generate
    for (genvar l = 0; l < LANES; l++) begin : g_lane
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          value[l*8 +: 8] <= '0;
          stb[l]          <= 1'b0;
        end else begin
          if (wr && be[l]) value[l*8 +: 8] <= wdata[l*8 +: 8];
          stb[l] <= wr & be[l];
        end
      end
    end
  endgenerate
endmodule

// File: rtl/dout_ctl_irq.sv
module dout_ctl_irq
  import dout_hs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctl_wr,
  input  logic [7:0] ctl_wdata,
  input  logic       data_wr,
  input  logic       reply_rise,
  input  logic       reply_fall,
  input  logic       irq_ack,
  output ctl_t       ctl,
  output logic       done_set,
  output logic       irq_req
);
  ctl_t ctl_q, ctl_d;
  logic irq_q, irq_d, done_clr, reply_hit, pair_now, pair_next;

  always_comb begin
    reply_hit = ctl_q.pos_edge ? reply_rise : reply_fall;
    done_set  = reply_hit | (ctl_wr & ctl_wdata[BIT_SIM]);
    done_clr  = data_wr | (ctl_wr & ~ctl_wdata[BIT_DONE]);

    ctl_d = ctl_q;
    if (ctl_wr) begin
      ctl_d.ie       = ctl_wdata[BIT_IE];
      ctl_d.defeat   = ctl_wdata[BIT_DEFEAT];
      ctl_d.pos_edge = ctl_wdata[BIT_POSEDGE];
    end
    if (done_set)      ctl_d.done = 1'b1;
    else if (done_clr) ctl_d.done = 1'b0;

    pair_now  = ctl_q.ie & ctl_q.done;
    pair_next = ctl_d.ie & ctl_d.done;
    irq_d     = (pair_next & ~pair_now) |
                (irq_q & pair_next & ~irq_ack);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q <= '0;
      irq_q <= 1'b0;
    end else begin
      ctl_q <= ctl_d;
      irq_q <= irq_d;
    end
  end

  assign ctl     = ctl_q;
  assign irq_req = irq_q;
endmodule

// File: rtl/dout_hs_port.sv
module dout_hs_port
  import dout_hs_pkg::*;
#(
  parameter logic [15:0] BASE_ADDR   = 16'o171260,
  parameter logic [15:0] VECTOR      = 16'o000340,
  parameter int unsigned SYNC_STAGES = 2,
  parameter logic        REPLY_IDLE  = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_sel,
  input  logic        bus_wr,
  input  logic [15:0] bus_addr,
  input  logic [1:0]  bus_be,
  input  logic [15:0] bus_wdata,
  output logic [15:0] bus_rdata,
  input  logic        panel_inv,
  input  logic        reply_in,
  output logic [15:0] dout,
  output logic [1:0]  dout_stb,
  input  logic        irq_ack
  ,output logic       irq_req
);
  localparam logic [15:0] DATA_ADDR = BASE_ADDR + 16'd2;

  logic        hit_ctl, hit_data, ctl_wr, data_wr;
  logic        r_rise, r_fall, done_set;
  logic [15:0] held;
  ctl_t        ctl;

  assign hit_ctl  = bus_sel && (bus_addr[15:1] == BASE_ADDR[15:1]);
  assign hit_data = bus_sel && (bus_addr[15:1] == DATA_ADDR[15:1]);
  assign ctl_wr   = hit_ctl && bus_wr && bus_be[0];
  assign data_wr  = hit_data && bus_wr && (bus_be != 2'b00);

  dout_reply_sync #(.STAGES(SYNC_STAGES), .IDLE(REPLY_IDLE)) i_sync (
    .clk(clk), .rst_n(rst_n), .async_in(reply_in),
    .rise(r_rise), .fall(r_fall)
  );

  dout_lane_reg #(.WIDTH(16)) i_lanes (
    .clk(clk), .rst_n(rst_n), .wr(hit_data && bus_wr), .be(bus_be),
    .wdata(bus_wdata), .value(held), .stb(dout_stb)
  );

  dout_ctl_irq i_ctl (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(bus_wdata[7:0]),
    .data_wr(data_wr), .reply_rise(r_rise), .reply_fall(r_fall),
    .irq_ack(irq_ack), .ctl(ctl), .done_set(done_set), .irq_req(irq_req)
  );

  assign dout = held ^ {16{panel_inv & ~ctl.defeat}};

  always_comb begin
    if (irq_ack && irq_req)     bus_rdata = VECTOR;
    else if (hit_ctl && !bus_wr)  bus_rdata = ctl_word(ctl);
    else if (hit_data && !bus_wr) bus_rdata = held;
    else                          bus_rdata = '0;
  end
endmodule

// File: rtl/dout_hs_checker.sv
module dout_hs_checker #(
  parameter logic [15:0] BASE_ADDR = 16'o171260,
  parameter logic [15:0] VECTOR    = 16'o000340
) (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_sel,
  input logic        bus_wr,
  input logic [15:0] bus_addr,
  input logic [1:0]  bus_be,
  input logic [15:0] bus_rdata,
  input logic [1:0]  dout_stb,
  input logic        irq_req,
  input logic        irq_ack,
  input logic        done,
  input logic        ie,
  input logic        done_set
);
  localparam logic [15:0] DATA_ADDR = BASE_ADDR + 16'd2;
  logic dwr_lo, dwr_hi, ctl_rd;
  assign dwr_lo = bus_sel && bus_wr && bus_addr[15:1] == DATA_ADDR[15:1] && bus_be[0];
  assign dwr_hi = bus_sel && bus_wr && bus_addr[15:1] == DATA_ADDR[15:1] && bus_be[1];
  assign ctl_rd = bus_sel && !bus_wr && bus_addr[15:1] == BASE_ADDR[15:1] && !irq_ack;

  p_stb_lo_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
    dout_stb[0] |-> $past(dwr_lo));
  p_stb_hi_follows_r3: assert property (@(posedge clk) disable iff (!rst_n)
    dwr_hi |=> dout_stb[1]);
  p_sim_reads_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_rd |-> bus_rdata[0] == 1'b0);
  p_data_clears_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (dwr_lo && !done_set) |=> !done);
  p_irq_needs_pair_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (done && ie));
  p_vector_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && irq_ack) |-> bus_rdata == VECTOR);
  p_ack_drops_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && irq_ack) |=> !irq_req);
endmodule

bind dout_hs_port dout_hs_checker #(.BASE_ADDR(BASE_ADDR), .VECTOR(VECTOR)) i_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_be(bus_be), .bus_rdata(bus_rdata),
  .dout_stb(dout_stb), .irq_req(irq_req), .irq_ack(irq_ack),
  .done(ctl.done), .ie(ctl.ie), .done_set(done_set)
);

// File: tb/test_dout_hs_port.sv
module test_dout_hs_port;
  localparam logic [15:0] A_CTL  = 16'o171260;
  localparam logic [15:0] A_DATA = 16'o171262;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [15:0] bus_addr = '0, bus_wdata = '0;
  logic [1:0]  bus_be = '0;
  logic [15:0] bus_rdata, dout;
  logic        panel_inv = 1'b0, reply_in = 1'b1, irq_ack = 1'b0;
  logic [1:0]  dout_stb;
  logic        irq_req;
  int          n_run = 0, n_fail = 0;
  logic [15:0] rd;

  always #10 clk = ~clk;

  dout_hs_port i_dout_hs_port (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .panel_inv(panel_inv), .reply_in(reply_in),
    .dout(dout), .dout_stb(dout_stb), .irq_ack(irq_ack), .irq_req(irq_req)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bwrite(input logic [15:0] a, input logic [1:0] be, input logic [15:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_be = be; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; bus_be = '0;
  endtask

  task automatic bread(input logic [15:0] a, output logic [15:0] d);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic t_reset;
    check("R1 dout", dout, 16'h0);
    check("R1 stb", {14'h0, dout_stb}, 16'h0);
    check("R1 irq", {15'h0, irq_req}, 16'h0);
    bread(A_CTL, rd);  check("R1 ctl", rd, 16'h0);
    bread(A_DATA, rd); check("R1 data", rd, 16'h0);
  endtask

  task automatic t_word;
    bwrite(A_DATA, 2'b11, 16'hA55A);
    check("R2 dout", dout, 16'hA55A);
    check("R2 stb high", {14'h0, dout_stb}, 16'h3);
    @(negedge clk);
    check("R2 stb one clock", {14'h0, dout_stb}, 16'h0);
  endtask

  task automatic t_byte;
    bwrite(A_DATA, 2'b01, 16'hFF3C);
    check("R3 low lane", dout, 16'hA53C);
    check("R3 low strobe", {14'h0, dout_stb}, 16'h1);
    bwrite(A_DATA, 2'b10, 16'h7E00);
    check("R3 high lane", dout, 16'h7E3C);
    check("R3 high strobe", {14'h0, dout_stb}, 16'h2);
    @(negedge clk);
  endtask

  task automatic t_panel;
    panel_inv = 1'b1;
    #1 check("R4 inverted", dout, ~16'h7E3C);
    bread(A_DATA, rd); check("R4 readback", rd, 16'h7E3C);
    bwrite(A_CTL, 2'b01, 16'h0010);
    check("R4 defeat", dout, 16'h7E3C);
    bwrite(A_CTL, 2'b01, 16'h0000);
    panel_inv = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reply;
    reply_in = 1'b0;
    repeat (2) @(negedge clk);
    bread(A_CTL, rd); check("R5 not yet", rd & 16'h0080, 16'h0);
    @(negedge clk);
    bread(A_CTL, rd); check("R5 falling sets", rd & 16'h0080, 16'h0080);
    bwrite(A_DATA, 2'b01, 16'h0011);
    bread(A_CTL, rd); check("R7 data write clears", rd & 16'h0080, 16'h0);
    reply_in = 1'b1;
    repeat (4) @(negedge clk);
    bread(A_CTL, rd); check("R5 rising ignored", rd & 16'h0080, 16'h0);
    bwrite(A_CTL, 2'b01, 16'h0008);
    reply_in = 1'b0;
    repeat (4) @(negedge clk);
    bread(A_CTL, rd); check("R5 falling ignored", rd & 16'h0080, 16'h0);
    reply_in = 1'b1;
    repeat (3) @(negedge clk);
    bread(A_CTL, rd); check("R5 rising sets", rd, 16'h0088);
    bwrite(A_CTL, 2'b01, 16'h0000);
    bread(A_CTL, rd); check("R7 ctl write clears", rd, 16'h0);
  endtask

  task automatic t_sim_fields;
    bwrite(A_CTL, 2'b01, 16'h0001);
    bread(A_CTL, rd); check("R6 sim sets, bit0 reads 0", rd, 16'h0080);
    bwrite(A_CTL, 2'b01, 16'h0080);
    bread(A_CTL, rd); check("R7 bit7=1 keeps done", rd, 16'h0080);
    bwrite(A_CTL, 2'b01, 16'hFF7E);
    bread(A_CTL, rd); check("R10 field readback", rd, 16'h0058);
    check("R9 no irq without done", {15'h0, irq_req}, 16'h0);
    bwrite(A_CTL, 2'b01, 16'h0000);
  endtask

  task automatic t_irq;
    bwrite(A_CTL, 2'b01, 16'h0040);
    bwrite(A_CTL, 2'b01, 16'h0041);
    check("R8 irq on done", {15'h0, irq_req}, 16'h1);
    irq_ack = 1'b1;
    #1 check("R8 vector", bus_rdata, 16'h00E0);
    @(negedge clk);
    irq_ack = 1'b0;
    check("R8 drop after ack", {15'h0, irq_req}, 16'h0);
    bwrite(A_DATA, 2'b11, 16'h1234);
    bwrite(A_CTL, 2'b01, 16'h0001);
    check("R9 ie clear no irq", {15'h0, irq_req}, 16'h0);
    bwrite(A_CTL, 2'b01, 16'h00C0);
    check("R8 irq on ie set", {15'h0, irq_req}, 16'h1);
    bwrite(A_CTL, 2'b01, 16'h0080);
    check("R9 ie clear drops", {15'h0, irq_req}, 16'h0);
    bread(A_CTL, rd); check("R9 done kept", rd, 16'h0080);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_word();
        t_byte();
        t_panel();
        t_reply();
        t_sim_fields();
        t_irq();
      end
      begin
        repeat (5000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule